// File: doc/BRIEF.md
# Single-Level Page Table Walker

This unit turns a virtual address into a physical address by fetching one translation entry from memory. A table base register names the table of the current address space. Loading it with a new value moves all later translations to another table, as is done when the running process changes. For each accepted request the unit adds the page-number field of the virtual address to the base and reads one 16-bit word at that address over a simple request/acknowledge memory port.

The fetched word is decoded. A missing page and a forbidden access each produce a fault code, and neither touches memory again. When the access is allowed, the frame number is joined to the untouched page offset to form the physical address. The entry's usage bits are updated: the referenced bit is set on any allowed access, and the modified bit is also set on an allowed write. The new word is written back to the same address, but only when its value has changed. The unit handles one translation at a time and stays busy until its response has been taken.

Top module: `ptw_unit`

## Requirements
- R1: While reset is asserted, and after it is released, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: An accepted request issues a read (mem_we_o=0) at mem_addr_o = table base + VA[19:11]. The virtual address is 20 bits, and VA[19:11] is the 9-bit page number. The sum is truncated to 16 bits.
- R3: A pulse on base_load_i loads base_val_i into the table base, which resets to 0. Requests accepted after the load use the new base. A load that arrives while a walk is running does not change the address of that walk.
- R4: When the entry allows the access, rsp_fault_o=0 and rsp_pa_o = {entry[4:0], VA[10:0]}. The frame number is entry bits 4:0, and the 11-bit offset passes through unchanged.
- R5: When entry bit 15 (valid) is 0, rsp_fault_o=1 (page fault) and rsp_pa_o=0, and the entry is not written.
- R6: Entry bit 12 enables reads and bit 11 enables writes. A valid entry whose matching enable bit is 0 gives rsp_fault_o=2 (protection fault), rsp_pa_o=0, and no write. A clear valid bit takes priority over protection.
- R7: An allowed access sets entry bit 14 (referenced). An allowed write also sets bit 13 (modified). The updated entry, with every other bit kept, is written to the same address only if it differs from the word read. Otherwise no write is issued.
- R8: req_ready_o is 0 from the cycle after acceptance until the response is taken. While rsp_valid_o=1 and rsp_ready_i=0, the response and its payload stay unchanged.
- R9: mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o stay stable until mem_ack_i is seen. For a read, mem_rdata_i is taken in the cycle in which mem_ack_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_load_i | input | 1 | Load the table base |
| base_val_i | input | 16 | New table base |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_va_i | input | 20 | Virtual address |
| req_write_i | input | 1 | Access is a write (1) or a read (0) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_pa_o | output | 16 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Word address of the entry |
| mem_wdata_o | output | 16 | Updated entry for write-back |
| mem_ack_i | input | 1 | Memory access done |
| mem_rdata_i | input | 16 | Entry read from memory |

## Verification
The hardest case to reach from the ports is a base reload that lands during a running walk. It has to arrive after the entry address has been captured but before the read completes. The bench makes this happen by slowing its memory model to a five-cycle acknowledge and pulsing base_load_i in the cycle after acceptance. It then checks that the read went to the old table and that the next request reads from the new one. The conditional write-back is reached by walking the same entry repeatedly, so its usage bits move from clear, to referenced, to modified, and finally to a state that needs no write.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W  = 16;
  localparam int V_BIT  = 15;
  localparam int R_BIT  = 14;
  localparam int D_BIT  = 13;
  localparam int RE_BIT = 12;
  localparam int WE_BIT = 11;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WBACK,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int MA_W  = 16,
  parameter int VPN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MA_W-1:0]  val_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [MA_W-1:0]  entry_addr_o
);
  logic [MA_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= val_i;
  end

  generate
    if (VPN_W >= MA_W) begin : g_trunc
      assign entry_addr_o = base_q + vpn_i[MA_W-1:0];
    end else begin : g_ext
      assign entry_addr_o = base_q + {{(MA_W-VPN_W){1'b0}}, vpn_i};
    end
  endgenerate
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PFN_W = 5
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  output fault_e           fault_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [PTE_W-1:0] pte_upd_o,
  output logic             wb_need_o
);
  logic allowed;

  assign allowed = is_write_i ? pte_i[WE_BIT] : pte_i[RE_BIT];
  assign pfn_o   = pte_i[PFN_W-1:0];

  always_comb begin
    if (!pte_i[V_BIT])  fault_o = FLT_PAGE;
    else if (!allowed)  fault_o = FLT_PROT;
    else                fault_o = FLT_NONE;
  end

  always_comb begin
    pte_upd_o        = pte_i;
    pte_upd_o[R_BIT] = 1'b1;
    if (is_write_i) pte_upd_o[D_BIT] = 1'b1;
  end

  assign wb_need_o = (pte_upd_o != pte_i);
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int OFF_W = 11,
  parameter int MA_W  = 16,
  parameter int PFN_W = 5,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic             req_write_i,
  input  logic [MA_W-1:0]  entry_addr_i,
  output logic             is_write_o,
  input  fault_e           chk_fault_i,
  input  logic [PFN_W-1:0] chk_pfn_i,
  input  logic [PTE_W-1:0] chk_upd_i,
  input  logic             chk_wb_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [MA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_pa_o,
  output fault_e           rsp_fault_o
);
  walk_st_e         st_q;
  logic [MA_W-1:0]  addr_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  pa_q;
  fault_e           fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      pte_q   <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= entry_addr_i;  // base captured here; later loads do not move this walk
          off_q  <= req_off_i;
          wr_q   <= req_write_i;
          st_q   <= ST_READ;
        end
        ST_READ: if (mem_ack_i) begin
          fault_q <= chk_fault_i;
          pa_q    <= (chk_fault_i == FLT_NONE) ? {chk_pfn_i, off_q} : '0;
          pte_q   <= chk_upd_i;
          st_q    <= (chk_fault_i == FLT_NONE && chk_wb_i) ? ST_WBACK : ST_RESP;
        end
        ST_WBACK: if (mem_ack_i) st_q <= ST_RESP;
        ST_RESP:  if (rsp_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign is_write_o  = wr_q;
  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WBACK);
  assign mem_we_o    = (st_q == ST_WBACK);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pte_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && mem_req_o && !mem_we_o);

  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o));

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                && $stable(mem_wdata_o));

  p_no_fault_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> fault_q == FLT_NONE);

  p_wb_ref_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[R_BIT] && (!wr_q || mem_wdata_o[D_BIT]));

  p_fault_pa_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != FLT_NONE |-> rsp_pa_o == '0);

  p_no_req_resp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && mem_req_o));
endmodule

// File: rtl/ptw_unit.sv
module ptw_unit
  import ptw_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int OFF_W = 11,
  parameter int MA_W  = 16,
  parameter int PFN_W = 5,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_load_i,
  input  logic [MA_W-1:0]  base_val_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [MA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [MA_W-1:0]  entry_addr;
  logic             is_write;
  fault_e           chk_fault;
  logic [PFN_W-1:0] chk_pfn;
  logic [PTE_W-1:0] chk_upd;
  logic             chk_wb;
  fault_e           fault_out;

  ptw_base_reg #(.MA_W(MA_W), .VPN_W(VPN_W)) base_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (base_load_i),
    .val_i        (base_val_i),
    .vpn_i        (req_va_i[VA_W-1:OFF_W]),
    .entry_addr_o (entry_addr)
  );

  ptw_pte_check #(.PFN_W(PFN_W)) check_i (
    .pte_i      (mem_rdata_i),
    .is_write_i (is_write),
    .fault_o    (chk_fault),
    .pfn_o      (chk_pfn),
    .pte_upd_o  (chk_upd),
    .wb_need_o  (chk_wb)
  );

  ptw_walk_fsm #(.OFF_W(OFF_W), .MA_W(MA_W), .PFN_W(PFN_W)) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_off_i    (req_va_i[OFF_W-1:0]),
    .req_write_i  (req_write_i),
    .entry_addr_i (entry_addr),
    .is_write_o   (is_write),
    .chk_fault_i  (chk_fault),
    .chk_pfn_i    (chk_pfn),
    .chk_upd_i    (chk_upd),
    .chk_wb_i     (chk_wb),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_pa_o     (rsp_pa_o),
    .rsp_fault_o  (fault_out)
  );

  assign rsp_fault_o = fault_out;

  p_wb_same_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !$past(mem_we_o) |-> $stable(mem_addr_o) && $past(mem_ack_i));
endmodule

// File: tb/ptw_unit_tb_top.sv
`timescale 1ns/1ps
module ptw_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_load = 1'b0;
  logic [15:0] base_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  ptw_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_load_i(base_load), .base_val_i(base_val),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model, acts at negedge
  logic [15:0] mem [0:1023];
  int          lat = 0, cnt = 0, rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic [15:0] last_rd, last_wr_addr, last_wr_data, pend_addr;
  logic        pend = 1'b0, pend_we;
  logic        poke_en = 1'b0;
  logic [15:0] poke_addr, poke_data;

  always @(negedge clk) begin
    if (poke_en) mem[poke_addr[9:0]] <= poke_data;
    if (pend && (!mem_req || mem_addr !== pend_addr || mem_we !== pend_we)) hold_err <= hold_err + 1;
    if (mem_ack) begin
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        pend    <= 1'b0;
        cnt     <= 0;
        if (mem_we) begin
          mem[mem_addr[9:0]] <= mem_wdata;
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[9:0]];
          rd_cnt    <= rd_cnt + 1;
          last_rd   <= mem_addr;
        end
      end else begin
        cnt       <= cnt + 1;
        pend      <= 1'b1;
        pend_addr <= mem_addr;
        pend_we   <= mem_we;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(posedge clk);
    poke_en = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic load_base(input logic [15:0] b);
    @(negedge clk);
    base_load = 1'b1; base_val = b;
    @(negedge clk);
    base_load = 1'b0;
  endtask

  logic [15:0] r_pa;
  logic [1:0]  r_fault;

  task automatic walk(input logic [19:0] va, input logic wr, input int stall,
                      input logic mid_ld, input logic [15:0] mid_base);
    int w;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (mid_ld) begin base_load = 1'b1; base_val = mid_base; end
    chk("R8 ready low after accept", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    base_load = 1'b0;
    w = 0;
    while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
    r_pa = rsp_pa; r_fault = rsp_fault;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R8 rsp held", {14'd0, rsp_valid, rsp_fault, rsp_pa}, {14'd0, 1'b1, r_fault, r_pa});
      chk("R8 busy while held", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    #1;
  endtask

  function automatic logic [15:0] pa_of(input logic [4:0] pfn, input logic [19:0] va);
    return {pfn, va[10:0]};
  endfunction

  task automatic t_reset();
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 idle after reset", {29'd0, req_ready, rsp_valid, mem_req}, 32'b100);
  endtask

  task automatic t_read_hit();
    int w0;
    logic [19:0] va = {9'd3, 11'h155};
    load_base(16'h0100);
    poke(16'h0103, 16'h9007);
    w0 = wr_cnt;
    walk(va, 1'b0, 3, 1'b0, '0);
    chk("R2 read addr", {16'd0, last_rd}, 32'h0103);
    chk("R4 pa", {16'd0, r_pa}, {16'd0, pa_of(5'd7, va)});
    chk("R4 fault none", {30'd0, r_fault}, 32'd0);
    chk("R7 one write-back", wr_cnt - w0, 1);
    chk("R7 ref set", {16'd0, mem[10'h103]}, 32'hD007);
  endtask

  task automatic t_read_no_change();
    int w0 = wr_cnt;
    walk({9'd3, 11'h001}, 1'b0, 0, 1'b0, '0);
    chk("R7 no write when unchanged", wr_cnt - w0, 0);
    chk("R4 pa again", {16'd0, r_pa}, 32'h3801);
  endtask

  task automatic t_write_prot_then_ok();
    int w0 = wr_cnt;
    walk({9'd3, 11'h7FF}, 1'b1, 0, 1'b0, '0);
    chk("R6 write prot fault", {30'd0, r_fault}, 32'd2);
    chk("R6 pa zero", {16'd0, r_pa}, 32'd0);
    chk("R6 no write", wr_cnt - w0, 0);
    chk("R6 entry untouched", {16'd0, mem[10'h103]}, 32'hD007);
    poke(16'h0103, 16'h8807);  // write-only, usage bits clear
    walk({9'd3, 11'h010}, 1'b0, 0, 1'b0, '0);
    chk("R6 read prot fault", {30'd0, r_fault}, 32'd2);
    w0 = wr_cnt;
    walk({9'd3, 11'h7FF}, 1'b1, 1, 1'b0, '0);
    chk("R7 write ok", {14'd0, r_fault, r_pa}, {16'd0, pa_of(5'd7, {9'd3, 11'h7FF})});
    chk("R7 ref+dirty written", {16'd0, last_wr_data}, 32'hE807);
    chk("R7 wb addr", {16'd0, last_wr_addr}, 32'h0103);
    chk("R7 one write", wr_cnt - w0, 1);
    w0 = wr_cnt;
    walk({9'd3, 11'h000}, 1'b1, 0, 1'b0, '0);
    chk("R7 dirty entry no write", wr_cnt - w0, 0);
  endtask

  task automatic t_invalid();
    int w0 = wr_cnt;
    poke(16'h0105, 16'h1807);
    walk({9'd5, 11'h123}, 1'b1, 0, 1'b0, '0);
    chk("R5 page fault", {30'd0, r_fault}, 32'd1);
    chk("R5 pa zero", {16'd0, r_pa}, 32'd0);
    chk("R5 no write", wr_cnt - w0, 0);
    poke(16'h0106, 16'h0000);
    walk({9'd6, 11'h000}, 1'b0, 0, 1'b0, '0);
    chk("R6 invalid beats prot", {30'd0, r_fault}, 32'd1);
    chk("R5 entry untouched", {16'd0, mem[10'h105]}, 32'h1807);
  endtask

  task automatic t_base_switch();
    poke(16'h0203, 16'h9011);
    load_base(16'h0200);
    walk({9'd3, 11'h0AB}, 1'b0, 0, 1'b0, '0);
    chk("R3 new table addr", {16'd0, last_rd}, 32'h0203);
    chk("R3 new frame", {16'd0, r_pa}, {16'd0, pa_of(5'd17, {9'd3, 11'h0AB})});
    lat = 5;
    poke(16'h0302, 16'h9002);
    walk({9'd2, 11'h004}, 1'b0, 0, 1'b1, 16'h0300);
    chk("R3 mid-walk load ignored", {16'd0, last_rd}, 32'h0202);
    walk({9'd2, 11'h004}, 1'b0, 2, 1'b0, '0);
    chk("R3 next walk new base", {16'd0, last_rd}, 32'h0302);
    chk("R3 frame from new table", {16'd0, r_pa}, 32'h1004);
    lat = 0;
  endtask

  task automatic t_wrap_max();
    poke(16'h00FF, 16'hD01F);
    load_base(16'hFF00);
    lat = 3;
    walk({9'h1FF, 11'h7FF}, 1'b0, 0, 1'b0, '0);
    chk("R2 address wraps", {16'd0, last_rd}, 32'h00FF);
    chk("R4 max pa", {16'd0, r_pa}, 32'hFFFF);
    chk("R9 request held until ack", hold_err, 0);
    lat = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_read_no_change();
    t_write_prot_then_ok();
    t_invalid();
    t_base_switch();
    t_wrap_max();
    chk("R8 idle at end", {31'd0, req_ready}, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule